// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes from a host into asynchronous serial frames on a single output line. It has two storage stages: a holding register that the host writes, and a frame shift register that drives the line. A host write fills the holding register and lowers the empty flag. At the next bit-rate enable pulse on which the shift register is free, the held character moves into the shift register. The empty flag then rises again, so the host can queue the following character while the current one is still being sent.

Each frame has a low start bit, 7 or 8 data bits sent least significant bit first, an optional odd or even parity bit, and one or two high stop bits. The format comes from mode inputs and is captured when a character moves into the shift register. An external bit-rate enable pulse sets the length of every bit. A transmit-enable input gates the whole block. An interrupt request output tells the host that the holding register can accept data.

Top module: `async_tx_buffered`

## Requirements
- R1: After reset, with transmit enabled, `txLine` is 1, `emptyFlag` is 1 and `irqReq` equals `irqEn`.
- R2: When transmit is enabled, a cycle with `wrStb`=1 stores `wrData` and drives `emptyFlag` to 0 from the next cycle. The character moves into the shift register on the first cycle with `bitTick`=1 in which the shift register is idle or is finishing its last stop bit. From the cycle after that pulse, `emptyFlag` reads 1 again.
- R3: A frame starts in the cycle after the transfer pulse with a start bit of value 0. The start bit lasts exactly one `bitTick` period, and so does every later bit.
- R4: After the start bit come the data bits, least significant bit first. With `charShort`=1 there are 7 of them (`wrData[6:0]`); with `charShort`=0 there are 8.
- R5: With `parityOn`=1, one parity bit follows the data bits. With `parityOdd`=1 the total count of ones over the data bits and the parity bit is odd; with `parityOdd`=0 it is even. With `parityOn`=0 there is no parity bit.
- R6: The frame ends with one stop bit of value 1 when `stopTwo`=0, and with two when `stopTwo`=1.
- R7: While transmit is enabled and no frame is being sent, `txLine` stays at 1, including while `emptyFlag` is 1.
- R8: `irqReq` is 1 exactly when `txEn`, `irqEn` and `emptyFlag` are all 1.
- R9: If a character is waiting when the last stop bit ends, the start bit of the next frame follows immediately, with no idle bit between the frames.
- R10: While `txEn`=0, `txLine` is 1 and `emptyFlag` is 1. Any frame in progress is abandoned, any held character is dropped and writes are ignored. After `txEn` returns to 1 the line stays idle until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Transmit enable |
| bitTick | input | 1 | Bit-rate enable pulse; one bit lasts one pulse period |
| wrStb | input | 1 | Host write strobe into the holding register |
| wrData | input | DATA_W | Character to send |
| charShort | input | 1 | 1: 7-bit characters, 0: 8-bit characters |
| parityOn | input | 1 | 1: a parity bit is added |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| stopTwo | input | 1 | 1: two stop bits, 0: one stop bit |
| irqEn | input | 1 | Enables the data-empty interrupt request |
| txLine | output | 1 | Serial output, idles high |
| emptyFlag | output | 1 | 1 when the holding register can take a character |
| irqReq | output | 1 | Data-empty interrupt request |

## Verification
The assertions check four things on every cycle. The line changes only after a bit-rate pulse. Every frame starts low, and the transfer into the shift register happens only on a pulse. A write clears the empty flag. The interrupt request never goes high without a set empty flag and an enabled interrupt. Frame contents can only be shown by the bench's scenarios: bit order, character length, parity sense and stop count, swept over all sixteen format settings and several data patterns. The same goes for back-to-back frames with no gap, and for the recovery after transmit is disabled in the middle of a frame.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeHold;   // capture host data into the holding register
    logic loadShift;  // move the held character into the frame shifter
    logic shiftOut;   // advance the frame by one bit
    logic flush;      // transmit disabled: drop everything
  } txStrobes_t;

  // Frame format selected by the mode inputs
  typedef struct packed {
    logic shortChar;
    logic parityOn;
    logic parityOdd;
    logic twoStop;
  } frameCfg_t;

endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             bitTick,
  input  logic             wrStb,
  input  logic [CNT_W-1:0] frameLen,
  output txStrobes_t       strobes,
  output logic             holdFull,
  output logic             shiftBusy
);

  logic [CNT_W-1:0] bitsLeft;
  logic             lastBitEnd;

  always_comb begin
    lastBitEnd        = shiftBusy && bitTick && (bitsLeft == CNT_W'(1));
    strobes.flush     = !txEn;
    strobes.takeHold  = txEn && wrStb;
    strobes.loadShift = txEn && bitTick && holdFull && (!shiftBusy || lastBitEnd);
    strobes.shiftOut  = txEn && bitTick && shiftBusy && !strobes.loadShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) begin
      holdFull  <= 1'b0;
      shiftBusy <= 1'b0;
      bitsLeft  <= '0;
    end else begin
      if (strobes.takeHold) begin
        holdFull <= 1'b1;
      end else if (strobes.loadShift) begin
        holdFull <= 1'b0;
      end

      if (strobes.loadShift) begin
        shiftBusy <= 1'b1;
        bitsLeft  <= frameLen;
      end else if (shiftBusy && bitTick) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
        if (lastBitEnd) begin
          shiftBusy <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/async_tx_dpath.sv
module async_tx_dpath
  import async_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_MAX = 12,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  frameCfg_t         cfg,
  output logic              serialBit,
  output logic [CNT_W-1:0]  frameLen
);

  logic [DATA_W-1:0]    holdReg;
  logic [DATA_W-1:0]    dataMask;
  logic [DATA_W-1:0]    maskedData;
  logic [FRAME_MAX-1:0] shiftReg;
  logic [FRAME_MAX-1:0] builtFrame;
  logic                 parityBit;
  int                   nData;

  always_comb begin
    dataMask   = cfg.shortChar ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    maskedData = holdReg & dataMask;
    parityBit  = (^maskedData) ^ cfg.parityOdd;
    nData      = cfg.shortChar ? DATA_W - 1 : DATA_W;
    frameLen   = CNT_W'(1) + CNT_W'(nData) + CNT_W'(cfg.parityOn)
               + (cfg.twoStop ? CNT_W'(2) : CNT_W'(1));
  end

  // Frame image, first bit on the line in position 0; unused tail stays high
  always_comb begin
    builtFrame    = '1;
    builtFrame[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (i < nData) begin
        builtFrame[1+i] = holdReg[i];
      end else if (i == nData && cfg.parityOn) begin
        builtFrame[1+i] = parityBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (strobes.takeHold) begin
        holdReg <= wrData;
      end
      if (strobes.flush) begin
        shiftReg <= '1;
      end else if (strobes.loadShift) begin
        shiftReg <= builtFrame;
      end else if (strobes.shiftOut) begin
        shiftReg <= {1'b1, shiftReg[FRAME_MAX-1:1]};
      end
    end
  end

  assign serialBit = shiftReg[0];

endmodule

// File: rtl/async_tx_buffered.sv
module async_tx_buffered
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEn,
  input  logic              bitTick,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              charShort,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              stopTwo,
  input  logic              irqEn,
  output logic              txLine,
  output logic              emptyFlag,
  output logic              irqReq
);

  localparam int FRAME_MAX = DATA_W + 4;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  txStrobes_t       strobes;
  frameCfg_t        cfg;
  logic [CNT_W-1:0] frameLen;
  logic             holdFull;
  logic             shiftBusy;
  logic             serialBit;

  assign cfg = '{shortChar: charShort, parityOn: parityOn,
                 parityOdd: parityOdd, twoStop: stopTwo};

  async_tx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEn      (txEn),
    .bitTick   (bitTick),
    .wrStb     (wrStb),
    .frameLen  (frameLen),
    .strobes   (strobes),
    .holdFull  (holdFull),
    .shiftBusy (shiftBusy)
  );

  async_tx_dpath #(.DATA_W(DATA_W), .FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .cfg       (cfg),
    .serialBit (serialBit),
    .frameLen  (frameLen)
  );

  assign txLine    = (txEn && shiftBusy) ? serialBit : 1'b1;
  assign emptyFlag = !(txEn && holdFull);
  assign irqReq    = txEn && irqEn && emptyFlag;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txEn,
  input logic bitTick,
  input logic wrStb,
  input logic irqEn,
  input logic txLine,
  input logic emptyFlag,
  input logic irqReq,
  input logic shiftBusy
);

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && wrStb) |=> (!emptyFlag || !txEn));

  assert_load_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftBusy) |-> $past(bitTick));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(shiftBusy) && txEn) |-> !txLine);

  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && $past(txEn) && !$past(bitTick)) |-> $stable(txLine));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (emptyFlag && irqEn && txEn));

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (emptyFlag && txLine && !shiftBusy));

endmodule

bind async_tx_buffered async_tx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txEn      (txEn),
  .bitTick   (bitTick),
  .wrStb     (wrStb),
  .irqEn     (irqEn),
  .txLine    (txLine),
  .emptyFlag (emptyFlag),
  .irqReq    (irqReq),
  .shiftBusy (shiftBusy)
);

// File: tb/sim_async_tx_buffered.sv
module sim_async_tx_buffered;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_P     = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b1;
  logic       bitTick = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       charShort = 1'b0;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       stopTwo = 1'b0;
  logic       irqEn = 1'b1;
  logic       txLine;
  logic       emptyFlag;
  logic       irqReq;

  int nChecks = 0;
  int nFails  = 0;

  async_tx_buffered #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .bitTick(bitTick), .wrStb(wrStb),
    .wrData(wrData), .charShort(charShort), .parityOn(parityOn),
    .parityOdd(parityOdd), .stopTwo(stopTwo), .irqEn(irqEn),
    .txLine(txLine), .emptyFlag(emptyFlag), .irqReq(irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bit-rate pulse: one cycle in every TICK_P
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % TICK_P;
      bitTick = (tc == 0);
    end
  end

  task automatic printSummary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: run did not finish act=1 exp=0");
    printSummary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Expected frame bits (first on line at index 0) and length
  task automatic expFrame(input logic [7:0] d, input logic [3:0] cfg,
                          output logic [11:0] bits, output int len, output int nData);
    int ones = 0;
    nData = cfg[3] ? 7 : 8;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nData; i++) begin
      bits[1+i] = d[i];
      ones += int'(d[i]);
    end
    len = 1 + nData;
    if (cfg[2]) begin
      bits[1+nData] = cfg[1] ? ((ones % 2) == 0) : ((ones % 2) == 1);
      len++;
    end
    len += cfg[0] ? 2 : 1;
  endtask

  task automatic setCfg(input logic [3:0] cfg);
    charShort = cfg[3]; parityOn = cfg[2]; parityOdd = cfg[1]; stopTwo = cfg[0];
  endtask

  // Called at the first negedge of the start bit; returns at the first
  // negedge after the last stop bit.
  task automatic watchFrame(input logic [7:0] d, input logic [3:0] cfg);
    logic [11:0] bits;
    int len, nData, idx;
    string req;
    expFrame(d, cfg, bits, len, nData);
    for (int k = 0; k < len * TICK_P; k++) begin
      if (k == TICK_P - 1)
        check(txLine == 1'b0, "R3 start bit length", int'(txLine), 0);
      if ((k % TICK_P) == TICK_P / 2) begin
        idx = k / TICK_P;
        if (idx == 0) req = "R3 start bit";
        else if (idx <= nData) req = "R4 data bit";
        else if (cfg[2] && idx == nData + 1) req = "R5 parity bit";
        else req = "R6 stop bit";
        check(txLine == bits[idx], req, int'(txLine), int'(bits[idx]));
      end
      @(negedge clk);
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    check(emptyFlag == 1'b0, "R2 write clears empty", int'(emptyFlag), 0);
  endtask

  task automatic waitFall(output bit found);
    found = 1'b0;
    for (int n = 0; n < 200; n++) begin
      if (txLine == 1'b0) begin
        found = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check(found, "R2 frame start after write", int'(found), 1);
  endtask

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'hC3};
    bit found;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 reset line", int'(txLine), 1);
    check(emptyFlag == 1'b1, "R1 reset empty", int'(emptyFlag), 1);
    check(irqReq == irqEn, "R1 reset irq", int'(irqReq), int'(irqEn));

    // Sweep all formats and data patterns
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 6; p++) begin
        setCfg(4'(c));
        writeByte(pats[p]);
        check(irqReq == 1'b0, "R8 irq low while full", int'(irqReq), 0);
        waitFall(found);
        if (found) begin
          check(emptyFlag == 1'b1, "R2 empty after transfer", int'(emptyFlag), 1);
          watchFrame(pats[p], 4'(c));
          check(txLine == 1'b1, "R7 idle after frame", int'(txLine), 1);
          repeat (2 * TICK_P) @(negedge clk);
          check(txLine == 1'b1, "R7 idle held high", int'(txLine), 1);
          check(irqReq == 1'b1, "R8 irq when empty", int'(irqReq), 1);
        end
      end
    end

    // Interrupt enable off
    irqEn = 1'b0;
    @(negedge clk);
    check(irqReq == 1'b0, "R8 irq masked", int'(irqReq), 0);
    irqEn = 1'b1;

    // Back-to-back frames
    setCfg(4'b0110);
    writeByte(8'h3C);
    waitFall(found);
    if (found) begin
      fork
        watchFrame(8'h3C, 4'b0110);
        begin
          @(negedge clk);
          wrData = 8'hE7; wrStb = 1'b1;
          @(negedge clk);
          wrStb = 1'b0;
          check(emptyFlag == 1'b0, "R9 second write pending", int'(emptyFlag), 0);
          check(irqReq == 1'b0, "R8 irq low while pending", int'(irqReq), 0);
        end
      join
      check(txLine == 1'b0, "R9 no gap before next start", int'(txLine), 0);
      watchFrame(8'hE7, 4'b0110);
      check(txLine == 1'b1, "R9 idle after second frame", int'(txLine), 1);
    end

    // Disable in mid-frame
    setCfg(4'b0000);
    writeByte(8'h00);
    waitFall(found);
    repeat (2 * TICK_P) @(negedge clk);
    txEn = 1'b0;
    @(negedge clk);
    check(txLine == 1'b1, "R10 disabled line high", int'(txLine), 1);
    check(emptyFlag == 1'b1, "R10 disabled empty", int'(emptyFlag), 1);
    check(irqReq == 1'b0, "R10 disabled irq low", int'(irqReq), 0);
    wrData = 8'h00; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    repeat (3 * TICK_P) @(negedge clk);
    check(txLine == 1'b1, "R10 write ignored line", int'(txLine), 1);
    check(emptyFlag == 1'b1, "R10 write ignored empty", int'(emptyFlag), 1);
    txEn = 1'b1;
    for (int n = 0; n < 6 * TICK_P; n++) begin
      @(negedge clk);
      if (txLine != 1'b1 || emptyFlag != 1'b1) begin
        check(1'b0, "R10 stays idle after enable", int'({txLine, emptyFlag}), 3);
        break;
      end
    end
    check(txLine == 1'b1, "R10 idle after re-enable", int'(txLine), 1);

    // Normal operation resumes
    setCfg(4'b1011);
    writeByte(8'h96);
    waitFall(found);
    if (found) watchFrame(8'h96, 4'b1011);
    check(txLine == 1'b1, "R7 idle after recovery frame", int'(txLine), 1);

    printSummary();
    $finish;
  end

endmodule